// File: doc/BRIEF.md
# Run-Gated Real-Time Clock Register

This block is a processor-side time-keeping register. It counts upward by one on each tick. The tick comes from one of two sources, picked by a configuration input. The first is a programmable divider of the system clock. The second is an external tick line, synchronised into the clock domain, whose rising edges are counted. Counting happens only while software has enabled it and the CPU-running status input is high. Ticks that arrive while the processor is halted are lost.

Software uses a small command interface. It can load a value into the register, enable counting and disable counting. The register contents are always visible on a read port. When the count passes from all ones to all zeros, a sticky overflow interrupt flag is raised. Software clears the flag with a write-one-to-clear command.

Top module: `run_gated_rtc`

## Requirements
- R1: After reset the count is zero, counting is off (`counting_on` = 0) and `irq_out` is 0.
- R2: A `wr_load` pulse puts `wr_data` into the register. The new value appears on `count_out` after the next clock edge, whether or not counting is enabled. If a tick falls on the same cycle as a load, that tick is dropped.
- R3: `cmd_enable` turns counting on and `cmd_disable` turns it off. If both are high in one cycle, counting ends up off. While counting is off, the count holds its value.
- R4: While counting is on and `cpu_running` is 1, each tick from the selected source raises the count by exactly one. While `cpu_running` is 0, ticks are ignored and the count holds.
- R5: With `tick_src` = 0 (internal source), ticks occur once every `div_ratio`+1 clock cycles. Any run of K·(`div_ratio`+1) consecutive cycles therefore holds exactly K ticks.
- R6: With `tick_src` = 1 (external source), each rising edge of `ext_tick` gives one tick. The tick takes effect within four clock cycles of the edge. Each high phase and each low phase of `ext_tick` must last at least two clock cycles.
- R7: A count step from all ones to all zeros sets `irq_out` on the same edge. The flag stays set until a cycle with `irq_clear` high and no wrap; that cycle clears it.
- R8: A wrap in the same cycle as `irq_clear` leaves `irq_out` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_running | input | 1 | High while the processor is running; gates counting |
| tick_src | input | 1 | Tick source: 0 internal divider, 1 external tick |
| div_ratio | input | DIV_W | Internal divider setting N; one tick per N+1 clocks |
| ext_tick | input | 1 | Asynchronous external tick line |
| wr_load | input | 1 | Load command for the count register |
| wr_data | input | W | Value to load |
| cmd_enable | input | 1 | Turn counting on |
| cmd_disable | input | 1 | Turn counting off (wins over enable) |
| irq_clear | input | 1 | Write-one-to-clear for the overflow flag |
| count_out | output | W | Current register contents |
| counting_on | output | 1 | Counting-enabled state |
| irq_out | output | 1 | Sticky overflow interrupt flag |

## Verification
The bench sweeps divider settings 0 to 7 and one large setting. For each, it counts ticks over windows that are whole multiples of the period. A divider off by one would gain or lose a tick per period, and that shows up as a wrong difference. It repeats the windows with the processor halted and with counting disabled, and with the external source at several pulse counts. A missing run gate, or double counting of a held-high external line, would show there. Loads are issued against a divider that ticks every cycle, so a design that let the tick through would read one above the loaded value. Wrap tests cover the flag being set, the flag holding, a clear, and a clear on the wrap edge itself. A clear given priority there would drop the interrupt.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } tick_src_e;
endpackage

// File: rtl/rtc_tick_div.sv
`timescale 1ns/1ps
module rtc_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] ratio,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q;

  // one-cycle pulse every ratio+1 clocks; >= copes with ratio shrinking
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      tick    <= 1'b0;
    end else if (phase_q >= ratio) begin
      phase_q <= '0;
      tick    <= 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
      tick    <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_edge_sync.sv
`timescale 1ns/1ps
module rtc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/rtc_core.sv
`timescale 1ns/1ps
module rtc_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         cpu_running,
  input  logic         wr_load,
  input  logic [W-1:0] wr_data,
  input  logic         cmd_enable,
  input  logic         cmd_disable,
  input  logic         irq_clear,
  output logic [W-1:0] count_q,
  output logic         en_q,
  output logic         irq_q
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic advance;
  logic wrap;

  assign advance = en_q & cpu_running & tick & ~wr_load;
  assign wrap    = advance & (count_q == ALL_ONES);

  always_ff @(posedge clk) begin
    if (rst)          count_q <= '0;
    else if (wr_load) count_q <= wr_data;
    else if (advance) count_q <= count_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)              en_q <= 1'b0;
    else if (cmd_disable) en_q <= 1'b0;
    else if (cmd_enable)  en_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)            irq_q <= 1'b0;
    else if (wrap)      irq_q <= 1'b1;
    else if (irq_clear) irq_q <= 1'b0;
  end
endmodule

// File: rtl/run_gated_rtc.sv
`timescale 1ns/1ps
module run_gated_rtc
  import rtc_pkg::*;
#(
  parameter int W           = 32,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_running,
  input  logic             tick_src,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic             ext_tick,
  input  logic             wr_load,
  input  logic [W-1:0]     wr_data,
  input  logic             cmd_enable,
  input  logic             cmd_disable,
  input  logic             irq_clear,
  output logic [W-1:0]     count_out,
  output logic             counting_on,
  output logic             irq_out
);
  logic      int_tick;
  logic      ext_rise;
  logic      sel_tick;
  tick_src_e src;

  assign src = tick_src_e'(tick_src);

  rtc_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .ratio (div_ratio),
    .tick  (int_tick)
  );

  rtc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (ext_tick),
    .rise     (ext_rise)
  );

  assign sel_tick = (src == SRC_EXTERNAL) ? ext_rise : int_tick;

  rtc_core #(.W(W)) u_core (
    .clk         (clk),
    .rst         (rst),
    .tick        (sel_tick),
    .cpu_running (cpu_running),
    .wr_load     (wr_load),
    .wr_data     (wr_data),
    .cmd_enable  (cmd_enable),
    .cmd_disable (cmd_disable),
    .irq_clear   (irq_clear),
    .count_q     (count_out),
    .en_q        (counting_on),
    .irq_q       (irq_out)
  );
endmodule

// File: rtl/run_gated_rtc_chk.sv
`timescale 1ns/1ps
module run_gated_rtc_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         cpu_running,
  input logic         wr_load,
  input logic [W-1:0] wr_data,
  input logic         cmd_enable,
  input logic         cmd_disable,
  input logic         irq_clear,
  input logic [W-1:0] count_out,
  input logic         counting_on,
  input logic         irq_out
);
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ALL_ONES = '1;

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    wr_load |=> count_out == $past(wr_data)); // R2

  AST_OFF_WINS: assert property (@(posedge clk) disable iff (rst)
    cmd_disable |=> !counting_on); // R3

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!counting_on && !wr_load) |=> $stable(count_out)); // R3

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!cpu_running && !wr_load) |=> $stable(count_out)); // R4

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    !wr_load |=> (count_out == $past(count_out)) ||
                 (count_out == $past(count_out) + ONE)); // R4

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!wr_load && count_out == ALL_ONES) |=> (count_out != '0) || irq_out); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_out && !irq_clear) |=> irq_out); // R7

  AST_RAISE_NEEDS_WRAP: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> (count_out == '0) && ($past(count_out) == ALL_ONES)); // R8
endmodule

bind run_gated_rtc run_gated_rtc_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_running (cpu_running),
  .wr_load     (wr_load),
  .wr_data     (wr_data),
  .cmd_enable  (cmd_enable),
  .cmd_disable (cmd_disable),
  .irq_clear   (irq_clear),
  .count_out   (count_out),
  .counting_on (counting_on),
  .irq_out     (irq_out)
);

// File: tb/test_run_gated_rtc.sv
`timescale 1ns/1ps
module test_run_gated_rtc;
  localparam int W = 32;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cpu_running = 1'b0;
  logic             tick_src = 1'b0;
  logic [DIV_W-1:0] div_ratio = '0;
  logic             ext_tick = 1'b0;
  logic             wr_load = 1'b0;
  logic [W-1:0]     wr_data = '0;
  logic             cmd_enable = 1'b0;
  logic             cmd_disable = 1'b0;
  logic             irq_clear = 1'b0;
  logic [W-1:0]     count_out;
  logic             counting_on;
  logic             irq_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  run_gated_rtc #(.W(W), .DIV_W(DIV_W)) i_run_gated_rtc (
    .clk(clk), .rst(rst), .cpu_running(cpu_running), .tick_src(tick_src),
    .div_ratio(div_ratio), .ext_tick(ext_tick), .wr_load(wr_load),
    .wr_data(wr_data), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .irq_clear(irq_clear), .count_out(count_out), .counting_on(counting_on),
    .irq_out(irq_out)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [W-1:0] v);
    wr_load = 1'b1; wr_data = v;
    cyc(1);
    wr_load = 1'b0;
  endtask

  task automatic enable_cmd();
    cmd_enable = 1'b1; cyc(1); cmd_enable = 1'b0;
  endtask

  task automatic disable_cmd();
    cmd_disable = 1'b1; cyc(1); cmd_disable = 1'b0;
  endtask

  task automatic int_window(input string req, input int n, input int k, input int exp);
    logic [W-1:0] a;
    tick_src = 1'b0; div_ratio = DIV_W'(n);
    cyc(n + 3);
    a = count_out;
    cyc(k * (n + 1));
    check(req, count_out - a, W'(exp));
  endtask

  task automatic ext_window(input string req, input int pulses, input int exp);
    logic [W-1:0] a;
    tick_src = 1'b1; ext_tick = 1'b0;
    cyc(6);
    a = count_out;
    for (int p = 0; p < pulses; p++) begin
      ext_tick = 1'b1; cyc(2 + (p % 3));
      ext_tick = 1'b0; cyc(2 + (p % 2));
    end
    cyc(6);
    check(req, count_out - a, W'(exp));
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    check("R1 count", count_out, '0);
    check("R1 enable", W'(counting_on), '0);
    check("R1 irq", W'(irq_out), '0);

    // R3 while disabled, count holds and load still works (R2)
    cpu_running = 1'b1;
    int_window("R3 disabled holds", 0, 10, 0);
    load(32'h1234_5678);
    check("R2 load while disabled", count_out, 32'h1234_5678);
    cyc(5);
    check("R3 disabled after load", count_out, 32'h1234_5678);

    // R3 both commands at once: off wins
    cmd_enable = 1'b1; cmd_disable = 1'b1; cyc(1);
    cmd_enable = 1'b0; cmd_disable = 1'b0;
    check("R3 disable wins", W'(counting_on), '0);
    enable_cmd();
    check("R3 enable", W'(counting_on), 1);

    // R5 sweep of divider settings
    for (int n = 0; n < 8; n++) begin
      int_window("R5 sweep", n, 5, 5);
      int_window("R5 sweep long", n, 13, 13);
    end
    int_window("R5 large ratio", 200, 2, 2);

    // R4 halted ignores ticks
    cpu_running = 1'b0;
    int_window("R4 halted internal", 0, 20, 0);
    int_window("R4 halted internal n3", 3, 5, 0);
    cpu_running = 1'b1;
    int_window("R4 running again", 1, 7, 7);

    // R6 external source
    for (int p = 1; p <= 6; p++) ext_window("R6 ext pulses", p, p);
    cpu_running = 1'b0;
    ext_window("R4 halted external", 4, 0);
    cpu_running = 1'b1;
    disable_cmd();
    ext_window("R3 disabled external", 3, 0);
    enable_cmd();
    ext_window("R6 ext after enable", 5, 5);

    // R2 load beats tick (divider ticks every cycle)
    tick_src = 1'b0; div_ratio = '0;
    cyc(3);
    load(32'h0000_00A0);
    check("R2 tick dropped on load", count_out, 32'h0000_00A0);
    cyc(1);
    check("R2 counts after load", count_out, 32'h0000_00A1);

    // R7 wrap raises sticky flag
    check("R7 flag clear before wrap", W'(irq_out), '0);
    load(32'hFFFF_FFFE);
    cyc(1);
    check("R7 pre wrap", count_out, 32'hFFFF_FFFF);
    check("R7 no flag before wrap", W'(irq_out), '0);
    cyc(1);
    check("R7 wrapped count", count_out, '0);
    check("R7 flag set", W'(irq_out), 1);
    cyc(10);
    check("R7 flag sticky", W'(irq_out), 1);
    irq_clear = 1'b1; cyc(1); irq_clear = 1'b0;
    check("R7 flag cleared", W'(irq_out), '0);

    // R8 clear on the wrap edge keeps the flag
    load(32'hFFFF_FFFE);
    cyc(1);
    irq_clear = 1'b1; cyc(1); irq_clear = 1'b0;
    check("R8 wrap with clear count", count_out, '0);
    check("R8 wrap with clear flag", W'(irq_out), 1);
    irq_clear = 1'b1; cyc(1); irq_clear = 1'b0;
    check("R8 later clear", W'(irq_out), '0);

    // R7 no flag from a load of zero
    load('0);
    cyc(2);
    check("R7 load zero no flag", W'(irq_out), '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule